// File: doc/BRIEF.md
# Programmable-Priority Interrupt Controller

This block sits next to a processor core and picks one interrupt to present. It watches 28 level-sensitive request lines and holds an enable bit for each of them. It also holds three 16-bit priority registers that a bus loads. Each register is split into four 4-bit level fields.

Three of the lines have hard-wired levels. Every other line takes its level from one field of one priority register, and several lines may share the same field. A source is eligible when three things are true: its request is pending, its enable is set, and its level is strictly above the core's current mask level. The core's block bit silences everything.

Among the eligible sources, the one with the highest level wins. A tie goes to the source with the higher index. The block raises a request flag and presents the fixed event code of the winner. The core uses that code when it decides to take the interrupt.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all pending bits are 0, all enable bits are 1 and all three priority registers read as 0. With every request line held high and mask level 0, the first result after reset is source 0 with code 0x400.
- R2: A write with `pw_en` high and `pw_sel` equal to 0, 1 or 2 loads `pw_data` into priority register A, B or C. The new levels apply from the cycle after the write edge. A write with `pw_sel` equal to 3 changes nothing.
- R3: Field p of a register occupies bits 4p+3..4p. Sources take their level as follows, with the index on the left:
  - 3 from C field 0
  - 4 from C field 3
  - 5 to 9 from C field 2
  - 10 from A field 3
  - 11 and 27 from A field 2
  - 12 and 13 from A field 1
  - 14 to 16 from A field 0
  - 17 to 20 from B field 1
  - 21 to 24 from C field 1
  - 25 from B field 3
  - 26 from B field 2
- R4: Sources 0, 1 and 2 have the fixed levels 6, 4 and 2. Priority writes never change these levels.
- R5: A source can win only if its level is strictly greater than `cpu_mask`. A source at level 0 never wins.
- R6: While `cpu_block` is 1, `irq` is 0 and `event_code` is 0, whatever is pending.
- R7: A pulse on `en_we` loads all 28 enable bits from `en_data`. A pending source whose enable bit is 0 never wins.
- R8: The winner is the eligible source with the highest level. Among eligible sources at the same level, the one with the higher index wins.
- R9: `event_code` is 0x400 + 0x20 × (winner index) while `irq` is 1, and 0 while `irq` is 0.
- R10: Request lines are sampled into pending bits on each clock edge. `irq` and `event_code` respond in the same cycle to changes of `cpu_mask` and `cpu_block`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_lines | input | 28 | Level request lines, one per source |
| pw_en | input | 1 | Priority register write strobe |
| pw_sel | input | 2 | Priority register select: 0=A, 1=B, 2=C, 3=none |
| pw_data | input | 16 | Priority register write data |
| en_we | input | 1 | Enable-bit load strobe |
| en_data | input | 28 | New enable bits |
| cpu_block | input | 1 | Core block bit, inhibits all interrupts |
| cpu_mask | input | 4 | Core current mask level |
| irq | output | 1 | Interrupt request to the core |
| event_code | output | 12 | Event code of the winning source |

## Verification
The bench goes after ties at equal level. An arbiter that kept the first match instead of the last would report source 26 where source 27 should win, or a lower member of a shared group where the highest should win.

It sweeps the mask level across every value for the fixed-level sources. A `>=` comparison would then let a level equal to the mask through, and level 0 would be taken at mask 0.

Shared fields are checked through many randomized register, enable and request mixes. These are compared against an arithmetic model, so a wrong nibble slice or a wrong register choice for any source shows up as a wrong code.

It also probes the write to select 3 and the block bit. A decoder that aliased select 3 onto a real register, or a block path that only gated `irq`, would leave a visible change at the ports.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int NSRC_DEF  = 28;
   localparam int LVL_BITS  = 4;
   localparam int FIELDS    = 4;
   localparam int NREG_DEF  = 3;
   localparam int CODE_BITS = 12;
   localparam logic [CODE_BITS-1:0] CODE_BASE = 12'h400;
   localparam logic [CODE_BITS-1:0] CODE_STEP = 12'h020;

   typedef struct packed {
      logic                fixed;
      logic [1:0]          reg_id;
      logic [1:0]          field;
      logic [LVL_BITS-1:0] lvl;
   } prio_src_t;

   // Source -> level origin. Index order is the tie-break order.
   function automatic prio_src_t src_map(input int i);
      prio_src_t m;
      m = '{fixed: 1'b0, reg_id: 2'd0, field: 2'd0, lvl: '0};
      case (i)
         0:  begin m.fixed = 1'b1; m.lvl = 4'd6; end
         1:  begin m.fixed = 1'b1; m.lvl = 4'd4; end
         2:  begin m.fixed = 1'b1; m.lvl = 4'd2; end
         3:  begin m.reg_id = 2'd2; m.field = 2'd0; end
         4:  begin m.reg_id = 2'd2; m.field = 2'd3; end
         5, 6, 7, 8, 9:
             begin m.reg_id = 2'd2; m.field = 2'd2; end
         10: begin m.reg_id = 2'd0; m.field = 2'd3; end
         11, 27:
             begin m.reg_id = 2'd0; m.field = 2'd2; end
         12, 13:
             begin m.reg_id = 2'd0; m.field = 2'd1; end
         14, 15, 16:
             begin m.reg_id = 2'd0; m.field = 2'd0; end
         17, 18, 19, 20:
             begin m.reg_id = 2'd1; m.field = 2'd1; end
         21, 22, 23, 24:
             begin m.reg_id = 2'd2; m.field = 2'd1; end
         25: begin m.reg_id = 2'd1; m.field = 2'd3; end
         26: begin m.reg_id = 2'd1; m.field = 2'd2; end
         default: begin m.fixed = 1'b1; m.lvl = '0; end
      endcase
      return m;
   endfunction

   function automatic logic [CODE_BITS-1:0] src_code(input int i);
      return CODE_BASE + CODE_STEP * CODE_BITS'(i);
   endfunction
endpackage

// File: rtl/irqc_state.sv
module irqc_state
   import irqc_pkg::*;
#(
   parameter int NSRC  = NSRC_DEF,
   parameter int REG_W = LVL_BITS * FIELDS,
   parameter int NREG  = NREG_DEF,
   parameter int SEL_W = 2
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NSRC-1:0]        req_lines,
   input  logic                   pw_en,
   input  logic [SEL_W-1:0]       pw_sel,
   input  logic [REG_W-1:0]       pw_data,
   input  logic                   en_we,
   input  logic [NSRC-1:0]        en_data,
   output logic [NREG*REG_W-1:0]  prio_q,
   output logic [NSRC-1:0]        en_q,
   output logic [NSRC-1:0]        pend_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         en_q   <= '1;
      end else begin
         pend_q <= req_lines;
         if (en_we) en_q <= en_data;
      end
   end

   for (genvar r = 0; r < NREG; r++) begin : g_preg
      always_ff @(posedge clk) begin
         if (!rst_n)
            prio_q[r*REG_W +: REG_W] <= '0;
         else if (pw_en && pw_sel == SEL_W'(r))
            prio_q[r*REG_W +: REG_W] <= pw_data;
      end
   end

   // R10
   pend_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> pend_q == $past(req_lines));

   // R2
   prio_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pw_en && 32'(pw_sel) < NREG) |=>
         prio_q[$past(pw_sel)*REG_W +: REG_W] == $past(pw_data));

   // R2
   prio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pw_en || 32'(pw_sel) >= NREG) |=> $stable(prio_q));
endmodule

// File: rtl/irqc_prio_map.sv
module irqc_prio_map
   import irqc_pkg::*;
#(
   parameter int NSRC  = NSRC_DEF,
   parameter int LVL_W = LVL_BITS,
   parameter int REG_W = LVL_BITS * FIELDS,
   parameter int NREG  = NREG_DEF
)(
   input  logic [NREG*REG_W-1:0] prio_q,
   output logic [NSRC*LVL_W-1:0] lvl
);
   for (genvar i = 0; i < NSRC; i++) begin : g_src
      localparam prio_src_t M = src_map(i);
      if (M.fixed) begin : g_fix
         assign lvl[i*LVL_W +: LVL_W] = LVL_W'(M.lvl);
      end else begin : g_prog
         localparam int BASE = int'(M.reg_id) * REG_W + int'(M.field) * LVL_W;
         assign lvl[i*LVL_W +: LVL_W] = prio_q[BASE +: LVL_W];
      end
   end
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
   parameter int NSRC  = 28,
   parameter int LVL_W = 4,
   localparam int IDX_W = $clog2(NSRC)
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NSRC*LVL_W-1:0]  lvl,
   input  logic [NSRC-1:0]        elig,
   output logic                   found,
   output logic [IDX_W-1:0]       win_idx,
   output logic [LVL_W-1:0]       win_lvl
);
   // Ascending scan with >= so that a later source wins a tie.
   always_comb begin
      found   = 1'b0;
      win_idx = '0;
      win_lvl = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (elig[i] && (!found || lvl[i*LVL_W +: LVL_W] >= win_lvl)) begin
            found   = 1'b1;
            win_idx = IDX_W'(i);
            win_lvl = lvl[i*LVL_W +: LVL_W];
         end
      end
   end

   // R8
   pick_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> elig[win_idx]);

   // R8
   pick_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !found |-> elig == '0);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irqc_pkg::*;
#(
   parameter int NSRC   = NSRC_DEF,
   parameter int LVL_W  = LVL_BITS,
   parameter int REG_W  = LVL_BITS * FIELDS,
   parameter int NREG   = NREG_DEF,
   parameter int SEL_W  = 2,
   parameter int CODE_W = CODE_BITS
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   req_lines,
   input  logic              pw_en,
   input  logic [SEL_W-1:0]  pw_sel,
   input  logic [REG_W-1:0]  pw_data,
   input  logic              en_we,
   input  logic [NSRC-1:0]   en_data,
   input  logic              cpu_block,
   input  logic [LVL_W-1:0]  cpu_mask,
   output logic              irq,
   output logic [CODE_W-1:0] event_code
);
   localparam int IDX_W = $clog2(NSRC);

   if (LVL_W != LVL_BITS || REG_W != LVL_W * FIELDS || CODE_W != CODE_BITS ||
       NSRC > 32 || NREG > (1 << SEL_W)) begin : g_cfg_bad
      $error("irq_prio_ctrl: unsupported parameter combination");
   end

   logic [NREG*REG_W-1:0] prio_q;
   logic [NSRC-1:0]       en_q, pend_q, elig;
   logic [NSRC*LVL_W-1:0] lvl;
   logic                  found;
   logic [IDX_W-1:0]      win_idx;
   logic [LVL_W-1:0]      win_lvl;

   irqc_state #(.NSRC(NSRC), .REG_W(REG_W), .NREG(NREG), .SEL_W(SEL_W)) u_state (
      .clk(clk), .rst_n(rst_n), .req_lines(req_lines),
      .pw_en(pw_en), .pw_sel(pw_sel), .pw_data(pw_data),
      .en_we(en_we), .en_data(en_data),
      .prio_q(prio_q), .en_q(en_q), .pend_q(pend_q));

   irqc_prio_map #(.NSRC(NSRC), .LVL_W(LVL_W), .REG_W(REG_W), .NREG(NREG)) u_map (
      .prio_q(prio_q), .lvl(lvl));

   for (genvar i = 0; i < NSRC; i++) begin : g_elig
      assign elig[i] = pend_q[i] & en_q[i] & ~cpu_block &
                       (lvl[i*LVL_W +: LVL_W] > cpu_mask);
   end

   irqc_pick #(.NSRC(NSRC), .LVL_W(LVL_W)) u_pick (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .elig(elig),
      .found(found), .win_idx(win_idx), .win_lvl(win_lvl));

   assign irq        = found;
   assign event_code = found ? src_code(int'(win_idx)) : '0;

   // R5
   win_above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> win_lvl > cpu_mask);

   // R7
   win_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (pend_q[win_idx] && en_q[win_idx]));

   // R6
   blk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_block |-> (!irq && event_code == '0));
endmodule

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [27:0] req_lines = '0;
   logic        pw_en = 1'b0;
   logic [1:0]  pw_sel = '0;
   logic [15:0] pw_data = '0;
   logic        en_we = 1'b0;
   logic [27:0] en_data = '0;
   logic        cpu_block = 1'b0;
   logic [3:0]  cpu_mask = '0;
   logic        irq;
   logic [11:0] event_code;

   int n_chk = 0, n_fail = 0;

   logic [15:0] sh_prio [3];
   logic [27:0] sh_en, sh_pend;

   always #4 clk = ~clk;

   irq_prio_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req_lines(req_lines),
      .pw_en(pw_en), .pw_sel(pw_sel), .pw_data(pw_data),
      .en_we(en_we), .en_data(en_data),
      .cpu_block(cpu_block), .cpu_mask(cpu_mask),
      .irq(irq), .event_code(event_code));

   function automatic int m_lvl(input int i);
      int r, f;
      if (i == 0) return 6;
      if (i == 1) return 4;
      if (i == 2) return 2;
      r = 0; f = 0;
      if (i == 3) begin r = 2; f = 0; end
      else if (i == 4) begin r = 2; f = 3; end
      else if (i <= 9) begin r = 2; f = 2; end
      else if (i == 10) begin r = 0; f = 3; end
      else if (i == 11 || i == 27) begin r = 0; f = 2; end
      else if (i <= 13) begin r = 0; f = 1; end
      else if (i <= 16) begin r = 0; f = 0; end
      else if (i <= 20) begin r = 1; f = 1; end
      else if (i <= 24) begin r = 2; f = 1; end
      else if (i == 25) begin r = 1; f = 3; end
      else begin r = 1; f = 2; end
      return int'((sh_prio[r] >> (4 * f)) & 16'hF);
   endfunction

   task automatic model(output logic e_irq, output logic [11:0] e_code);
      int best, bi;
      best = -1; bi = 0;
      for (int i = 0; i < 28; i++)
         if (sh_pend[i] && sh_en[i] && !cpu_block && m_lvl(i) > int'(cpu_mask) &&
             m_lvl(i) >= best) begin
            best = m_lvl(i); bi = i;
         end
      e_irq  = (best >= 0);
      e_code = e_irq ? 12'(12'h400 + 12'h020 * bi) : 12'h000;
   endtask

   task automatic check(input string tag, input logic x_irq, input logic [11:0] x_code);
      n_chk++;
      if (irq !== x_irq || event_code !== x_code) begin
         n_fail++;
         $display("FAIL %s: irq=%0b code=%h expected irq=%0b code=%h",
                  tag, irq, event_code, x_irq, x_code);
      end
   endtask

   task automatic check_model(input string tag);
      logic ei; logic [11:0] ec;
      model(ei, ec);
      check(tag, ei, ec);
   endtask

   task automatic do_write(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk);
      pw_en = 1'b1; pw_sel = sel; pw_data = d;
      @(negedge clk);
      pw_en = 1'b0;
      if (sel < 2'd3) sh_prio[sel] = d;
   endtask

   task automatic set_en(input logic [27:0] e);
      @(negedge clk);
      en_we = 1'b1; en_data = e;
      @(negedge clk);
      en_we = 1'b0;
      sh_en = e;
   endtask

   task automatic set_req(input logic [27:0] r);
      @(negedge clk);
      req_lines = r;
      @(negedge clk);
      sh_pend = r;
   endtask

   initial begin
      #(200000 * 8);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      sh_prio[0] = '0; sh_prio[1] = '0; sh_prio[2] = '0;
      sh_en = '1; sh_pend = '0;
      req_lines = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: outputs while pending bits are still clear
      check("R1 reset quiet", 1'b0, 12'h000);
      @(negedge clk);
      sh_pend = '1;
      // R1: priority regs 0 and enables 1 leave source 0 on top
      check("R1 reset state", 1'b1, 12'h400);

      // R4 + R5: each fixed source alone, sweep every mask level
      for (int s = 0; s < 3; s++) begin
         set_req(28'(1) << s);
         for (int m = 0; m < 16; m++) begin
            #1 cpu_mask = 4'(m);
            #1;
            // R10: mask change seen without a clock edge
            check($sformatf("R4 R5 src%0d mask%0d", s, m),
                  (6 - 2 * s) > m, ((6 - 2 * s) > m) ? 12'(12'h400 + 12'h020 * s) : 12'h000);
         end
      end
      cpu_mask = '0;

      // R4: priority writes do not touch fixed levels
      do_write(2'd0, 16'hFFFF); do_write(2'd1, 16'hFFFF); do_write(2'd2, 16'hFFFF);
      set_req(28'h7);
      cpu_mask = 4'd5;
      #1 check("R4 fixed unchanged", 1'b1, 12'h400);
      cpu_mask = '0;

      // R8: all fields 7, ties go to highest index
      do_write(2'd0, 16'h7777); do_write(2'd1, 16'h7777); do_write(2'd2, 16'h7777);
      set_req('1);
      check("R8 tie top index", 1'b1, 12'h760);
      set_en(~(28'(1) << 27));
      check("R8 tie next index", 1'b1, 12'h740);
      // R7: disabling everything silences the block
      set_en('0);
      check("R7 all disabled", 1'b0, 12'h000);
      set_en('1);

      // R3: shared serial field wins at 9, highest member first
      do_write(2'd0, 16'h1111); do_write(2'd2, 16'h1111);
      // R2: new level visible the cycle after the write edge
      do_write(2'd1, 16'h0090);
      check("R2 R3 shared field", 1'b1, 12'h680);
      set_en(~(28'(1) << 20));
      check("R7 R3 shared next", 1'b1, 12'h660);
      set_en('1);

      // R2: select 3 writes nothing
      do_write(2'd3, 16'hFFFF);
      check("R2 select3 ignored", 1'b1, 12'h680);

      // R6: block bit
      cpu_block = 1'b1;
      #1 check("R6 block", 1'b0, 12'h000);
      cpu_block = 1'b0;
      #1 check("R6 unblock", 1'b1, 12'h680);

      // R5: level 0 never taken
      do_write(2'd0, 16'h0); do_write(2'd1, 16'h0); do_write(2'd2, 16'h0);
      set_req(28'h0FFFFF8);
      check("R5 level zero", 1'b0, 12'h000);

      // R3 R8 R9: randomized mixes against the model
      for (int it = 0; it < 600; it++) begin
         if (it % 4 == 0) do_write(2'($urandom_range(0, 2)), 16'($urandom));
         @(negedge clk);
         req_lines = 28'($urandom);
         en_we = 1'b1; en_data = 28'($urandom) | 28'($urandom);
         cpu_mask = 4'($urandom_range(0, 9));
         cpu_block = ($urandom_range(0, 15) == 0);
         @(negedge clk);
         en_we = 1'b0;
         sh_pend = req_lines; sh_en = en_data;
         check_model($sformatf("R3 R8 R9 random %0d", it));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule